// File: doc/BRIEF.md
# Four-Channel Register-Started Word Copier

The block holds four identical copy channels behind a small register file. Software programs each channel with two addresses, a byte length and a direction. The copy then starts only when two separate control bits, an enable and a start, both hold 1. A single shared engine moves the data one 32-bit word at a time over a simple request/acknowledge memory port. Each word is read from the source and then written to the destination.

When a channel's copy finishes, its start bit drops back to 0 and the block pulses a completion event whose number is a configurable base plus the channel index. When several channels are waiting at once, the engine serves them one after another, and the lowest channel number goes first.

The register port is word addressed. Byte address = `reg_addr` × 4, and each channel occupies a 32-byte window at byte offset channel × 32.

Top module: `quad_xfer_dma`

## Requirements
- R1: After reset, every channel register reads 0, `mem_req` is 0 and `evt_valid` is 0.
- R2: Registers sit at byte address channel×32 + offset, and each write keeps only the bits of its own mask:
  - external address, offset 0x00: mask 0x9FFFFFE0
  - system address, offset 0x04: mask 0x9FFFFFE0
  - length, offset 0x08: mask 0x9FFFFFE0
  - direction, offset 0x0C: bit 0
  - mode, offset 0x10: bits 2:0
  - enable, offset 0x14: bit 0
  - start, offset 0x18: bit 0
  - stop, offset 0x1C: mask 0x37
- R3: Writing 1 to start while enable is 0 leaves start reading 0, and no memory request or event follows.
- R4: With direction 0, words are read from the system address and written to the external address; with direction 1, the copy runs the other way. A read handshake has `mem_we`=0 and a write handshake has `mem_we`=1, each handshake moves one 32-bit word, and both addresses step by 4.
- R5: The number of words copied is bits 28:0 of the length register divided by 4. A length of 0 completes with no memory access.
- R6: On completion, start reads 0 and `evt_valid` is high for exactly one cycle with `evt_id` = EVT_BASE + channel.
- R7: When several channels are pending, they complete in increasing channel order.
- R8: While a channel's start reads 1, writes to its address and length registers are ignored.
- R9: Once raised, `mem_req` stays high with stable `mem_addr` and `mem_we` until `mem_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | CHW+3 | Register word address (byte address / 4) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid with `mem_ack` |
| mem_ack | input | 1 | Memory handshake acknowledge |
| evt_valid | output | 1 | Completion event pulse |
| evt_id | output | EVW | Completion event number |

## Verification
A table of masked writes is walked over every channel. It shows the per-register masks apart and confirms the 32-byte stride. Copies are run in both directions, so a swapped source or destination shows up as wrong memory contents.

A length of zero and a length with bits above bit 28 set separate the word-count rule from the stored mask. A start without enable shows that the cancel takes effect. Three channels are made pending under a long copy. The order of their events checks the priority, and attempts to rewrite the busy channel's address check that writes are blocked while busy.

// File: rtl/qdma_pkg.sv
// Shared types and register layout for the four-channel word copier.
// Assumes 32-bit registers and an 8-register window per channel.
package qdma_pkg;
    typedef enum logic [1:0] {ST_IDLE, ST_READ, ST_WRITE, ST_FIN} eng_state_e;

    localparam logic [2:0] OFF_EXT   = 3'd0;
    localparam logic [2:0] OFF_SYS   = 3'd1;
    localparam logic [2:0] OFF_LEN   = 3'd2;
    localparam logic [2:0] OFF_DIR   = 3'd3;
    localparam logic [2:0] OFF_MODE  = 3'd4;
    localparam logic [2:0] OFF_EN    = 3'd5;
    localparam logic [2:0] OFF_START = 3'd6;
    localparam logic [2:0] OFF_STOP  = 3'd7;

    localparam logic [31:0] MASK_ADDR = 32'h9FFF_FFE0;
    localparam logic [5:0]  MASK_STOP = 6'h37;
endpackage

// File: rtl/qdma_chan_regs.sv
// One channel's register set. It applies the per-register write masks,
// implements the two-bit start rule and blocks writes while pending.
// Assumes wr_en is already decoded for this channel.
module qdma_chan_regs
    import qdma_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [2:0]  wr_off,
    input  logic [31:0] wdata,
    input  logic [2:0]  rd_off,
    input  logic        done,
    output logic [31:0] rdata,
    output logic [31:0] ext_addr,
    output logic [31:0] sys_addr,
    output logic [31:0] len,
    output logic        dir,
    output logic        pending
);
    logic [2:0] mode_q;
    logic [5:0] stop_q;
    logic       en_q;
    logic       start_q;

    // Register updates: masked writes, start gating, completion clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ext_addr <= '0;
            sys_addr <= '0;
            len      <= '0;
            dir      <= 1'b0;
            mode_q   <= '0;
            stop_q   <= '0;
            en_q     <= 1'b0;
            start_q  <= 1'b0;
        end else begin
            if (done) start_q <= 1'b0;
            if (wr_en) begin
                case (wr_off)
                    OFF_EXT:   if (!start_q) ext_addr <= wdata & MASK_ADDR;
                    OFF_SYS:   if (!start_q) sys_addr <= wdata & MASK_ADDR;
                    OFF_LEN:   if (!start_q) len      <= wdata & MASK_ADDR;
                    OFF_DIR:   dir    <= wdata[0];
                    OFF_MODE:  mode_q <= wdata[2:0];
                    OFF_EN:    en_q   <= wdata[0];
                    OFF_START: if (!start_q) start_q <= wdata[0] & en_q;
                    default:   stop_q <= wdata[5:0] & MASK_STOP;
                endcase
            end
        end
    end

    assign pending = start_q;

    // Read-back multiplexer.
    always_comb begin
        case (rd_off)
            OFF_EXT:   rdata = ext_addr;
            OFF_SYS:   rdata = sys_addr;
            OFF_LEN:   rdata = len;
            OFF_DIR:   rdata = {31'd0, dir};
            OFF_MODE:  rdata = {29'd0, mode_q};
            OFF_EN:    rdata = {31'd0, en_q};
            OFF_START: rdata = {31'd0, start_q};
            default:   rdata = {26'd0, stop_q};
        endcase
    end

    assert_rise_needs_en_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(start_q) |-> en_q);
    assert_done_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !start_q);
    assert_busy_ext_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (start_q && wr_en && wr_off == OFF_EXT) |=> $stable(ext_addr));
endmodule

// File: rtl/qdma_arb.sv
// Fixed-priority selector: the lowest-numbered pending channel wins.
// Purely combinational; the engine samples it only when idle.
module qdma_arb #(
    parameter int NCH = 4,
    localparam int CHW = $clog2(NCH)
) (
    input  logic [NCH-1:0] req,
    output logic           any,
    output logic [CHW-1:0] idx
);
    // Scan from the top down so the lowest index is assigned last.
    always_comb begin
        idx = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (req[i]) idx = CHW'(i);
        end
        any = |req;
    end
endmodule

// File: rtl/qdma_engine.sv
// Shared copy engine. It latches the granted channel's parameters, then
// alternates read and write handshakes, one word each, and finishes with
// a one-cycle completion. Assumes the memory holds mem_rdata valid with mem_ack.
module qdma_engine
    import qdma_pkg::*;
#(
    parameter int NCH      = 4,
    parameter int EVT_BASE = 8,
    parameter int EVW      = 8,
    localparam int CHW = $clog2(NCH),
    localparam int LW  = 27
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           go,
    input  logic [CHW-1:0] go_idx,
    input  logic [31:0]    ext_in,
    input  logic [31:0]    sys_in,
    input  logic [LW-1:0]  words_in,
    input  logic           dir_in,
    output logic [NCH-1:0] done_vec,
    output logic           mem_req,
    output logic           mem_we,
    output logic [31:0]    mem_addr,
    output logic [31:0]    mem_wdata,
    input  logic [31:0]    mem_rdata,
    input  logic           mem_ack,
    output logic           evt_valid,
    output logic [EVW-1:0] evt_id
);
    eng_state_e     state;
    logic [CHW-1:0] cur;
    logic [31:0]    src;
    logic [31:0]    dst;
    logic [LW-1:0]  cnt;
    logic [31:0]    dbuf;

    // Sequencer: grant latch, read/write alternation, count-down.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cur   <= '0;
            src   <= '0;
            dst   <= '0;
            cnt   <= '0;
            dbuf  <= '0;
        end else begin
            case (state)
                ST_IDLE: if (go) begin
                    cur   <= go_idx;
                    src   <= dir_in ? ext_in : sys_in;
                    dst   <= dir_in ? sys_in : ext_in;
                    cnt   <= words_in;
                    state <= (words_in == '0) ? ST_FIN : ST_READ;
                end
                ST_READ: if (mem_ack) begin
                    dbuf  <= mem_rdata;
                    state <= ST_WRITE;
                end
                ST_WRITE: if (mem_ack) begin
                    src <= src + 32'd4;
                    dst <= dst + 32'd4;
                    cnt <= cnt - LW'(1);
                    state <= (cnt == LW'(1)) ? ST_FIN : ST_READ;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign mem_req   = (state == ST_READ) || (state == ST_WRITE);
    assign mem_we    = (state == ST_WRITE);
    assign mem_addr  = (state == ST_WRITE) ? dst : src;
    assign mem_wdata = dbuf;
    assign evt_valid = (state == ST_FIN);
    assign evt_id    = EVW'(EVT_BASE) + EVW'(cur);

    // Completion strobe decoded to the finishing channel.
    always_comb begin
        done_vec = '0;
        if (state == ST_FIN) done_vec[cur] = 1'b1;
    end

    assert_req_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));
    assert_evt_once_R6: assert property (@(posedge clk) disable iff (!rst_n)
        evt_valid |=> !evt_valid);
    assert_zero_len_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && go && words_in == '0) |=> (evt_valid && !mem_req));
endmodule

// File: rtl/quad_xfer_dma.sv
// Top level: NCH register-started copy channels sharing one engine.
// The register port is word addressed; channel = reg_addr[CHW+2:3].
// Assumes single-cycle register writes and combinational reads.
module quad_xfer_dma #(
    parameter int NCH      = 4,
    parameter int EVT_BASE = 8,
    parameter int EVW      = 8,
    localparam int CHW = $clog2(NCH),
    localparam int WAW = CHW + 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           reg_wr,
    input  logic [WAW-1:0] reg_addr,
    input  logic [31:0]    reg_wdata,
    output logic [31:0]    reg_rdata,
    output logic           mem_req,
    output logic           mem_we,
    output logic [31:0]    mem_addr,
    output logic [31:0]    mem_wdata,
    input  logic [31:0]    mem_rdata,
    input  logic           mem_ack,
    output logic           evt_valid,
    output logic [EVW-1:0] evt_id
);
    logic [31:0]    ch_rdata [NCH];
    logic [31:0]    ch_ext   [NCH];
    logic [31:0]    ch_sys   [NCH];
    logic [31:0]    ch_len   [NCH];
    logic [NCH-1:0] ch_dir;
    logic [NCH-1:0] ch_pend;
    logic [NCH-1:0] ch_done;
    logic           arb_any;
    logic [CHW-1:0] arb_idx;
    logic [CHW-1:0] sel_ch;

    assign sel_ch = reg_addr[WAW-1:3];

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        qdma_chan_regs u_regs (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (reg_wr && (sel_ch == CHW'(g))),
            .wr_off   (reg_addr[2:0]),
            .wdata    (reg_wdata),
            .rd_off   (reg_addr[2:0]),
            .done     (ch_done[g]),
            .rdata    (ch_rdata[g]),
            .ext_addr (ch_ext[g]),
            .sys_addr (ch_sys[g]),
            .len      (ch_len[g]),
            .dir      (ch_dir[g]),
            .pending  (ch_pend[g])
        );
    end

    assign reg_rdata = ch_rdata[sel_ch];

    qdma_arb #(.NCH(NCH)) u_arb (
        .req (ch_pend),
        .any (arb_any),
        .idx (arb_idx)
    );

    qdma_engine #(.NCH(NCH), .EVT_BASE(EVT_BASE), .EVW(EVW)) u_eng (
        .clk       (clk),
        .rst_n     (rst_n),
        .go        (arb_any),
        .go_idx    (arb_idx),
        .ext_in    (ch_ext[arb_idx]),
        .sys_in    (ch_sys[arb_idx]),
        .words_in  (ch_len[arb_idx][28:2]),
        .dir_in    (ch_dir[arb_idx]),
        .done_vec  (ch_done),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata),
        .mem_ack   (mem_ack),
        .evt_valid (evt_valid),
        .evt_id    (evt_id)
    );

    assert_done_was_pending_R6: assert property (@(posedge clk) disable iff (!rst_n)
        evt_valid |-> |(ch_done & ch_pend));
endmodule

// File: tb/quad_xfer_dma_test.sv
module quad_xfer_dma_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mem_req, mem_we, mem_ack;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic        evt_valid;
    logic [7:0]  evt_id;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    logic [31:0] mem [64];
    logic [31:0] snap [64];
    logic        ack_q;
    logic [31:0] rdq;
    int          acc_n;
    int          evt_n;
    logic [7:0]  evt_log [8];

    always #2 clk = ~clk;

    quad_xfer_dma uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_ack(mem_ack), .evt_valid(evt_valid),
        .evt_id(evt_id)
    );

    assign mem_ack   = ack_q;
    assign mem_rdata = rdq;

    // Memory model: acknowledge one cycle after a request is seen.
    always @(posedge clk) begin
        if (!rst_n) begin
            ack_q <= 1'b0;
        end else if (mem_req && !ack_q) begin
            ack_q <= 1'b1;
            acc_n <= acc_n + 1;
            if (mem_we) mem[mem_addr[7:2]] <= mem_wdata;
            else        rdq <= mem[mem_addr[7:2]];
        end else begin
            ack_q <= 1'b0;
        end
    end

    // Event recorder.
    always @(posedge clk) begin
        if (rst_n && evt_valid) begin
            if (evt_n < 8) evt_log[evt_n] <= evt_id;
            evt_n <= evt_n + 1;
        end
    end

    typedef struct packed {
        logic [2:0]  off;
        logic [31:0] wd;
        logic [31:0] ex;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{3'd0, 32'hFFFF_FFFF, 32'h9FFF_FFE0},
        '{3'd1, 32'hFFFF_FFFF, 32'h9FFF_FFE0},
        '{3'd2, 32'h1234_5678, 32'h1234_5660},
        '{3'd3, 32'hFFFF_FFFF, 32'h0000_0001},
        '{3'd4, 32'hFFFF_FFFF, 32'h0000_0007},
        '{3'd4, 32'h0000_000A, 32'h0000_0002},
        '{3'd7, 32'hFFFF_FFFF, 32'h0000_0037},
        '{3'd7, 32'h0000_00C8, 32'h0000_0000}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    task automatic wreg(input int ch, input int off, input logic [31:0] d);
        @(negedge clk);
        reg_addr  = 5'(ch * 8 + off);
        reg_wdata = d;
        reg_wr    = 1'b1;
        @(negedge clk);
        reg_wr    = 1'b0;
    endtask

    task automatic rreg(input int ch, input int off, output logic [31:0] d);
        @(negedge clk);
        reg_addr = 5'(ch * 8 + off);
        #1 d = reg_rdata;
    endtask

    task automatic wait_evts(input int target);
        for (int i = 0; i < 2000 && evt_n < target; i++) @(negedge clk);
    endtask

    task automatic setup(input int ch, input logic [31:0] ext, input logic [31:0] sys,
                         input logic [31:0] ln, input logic d);
        wreg(ch, 0, ext);
        wreg(ch, 1, sys);
        wreg(ch, 2, ln);
        wreg(ch, 3, {31'd0, d});
        wreg(ch, 5, 32'd1);
    endtask

    initial begin
        #(200000 * 4);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog (all R) actual=timeout expected=completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        logic        ok;
        int          a0;
        acc_n = 0;
        evt_n = 0;
        rdq   = '0;
        for (int i = 0; i < 64; i++) mem[i] = 32'hA500_0000 | 32'(i);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        ok = 1'b1;
        for (int c = 0; c < 4; c++)
            for (int o = 0; o < 8; o++) begin
                rreg(c, o, v);
                if (v !== 32'd0) ok = 1'b0;
            end
        chk("R1 all registers zero", {31'd0, ok}, 32'd1);
        chk("R1 mem_req idle", {31'd0, mem_req}, 32'd0);
        chk("R1 evt_valid idle", {31'd0, evt_valid}, 32'd0);

        // R2: write masks and 32-byte stride, every channel
        for (int c = 0; c < 4; c++)
            for (int k = 0; k < 8; k++) begin
                wreg(c, int'(VECS[k].off), VECS[k].wd);
                rreg(c, int'(VECS[k].off), v);
                chk($sformatf("R2 ch%0d off%0d mask", c, VECS[k].off), v, VECS[k].ex);
            end
        wreg(0, 6, 32'd0);
        rreg(1, 6, v);
        chk("R2 neighbour start untouched", v, 32'd0);

        // R3: start without enable is cancelled
        a0 = acc_n;
        wreg(1, 5, 32'd0);
        wreg(1, 6, 32'd1);
        rreg(1, 6, v);
        chk("R3 start reads 0 when disabled", v, 32'd0);
        repeat (10) @(negedge clk);
        chk("R3 no memory access", 32'(acc_n - a0), 32'd0);
        chk("R3 no event", 32'(evt_n), 32'd0);

        // R4 dir 0: system -> external, 8 words 16..23 -> 32..39
        a0 = acc_n;
        setup(0, 32'h80, 32'h40, 32'h20, 1'b0);
        wreg(0, 6, 32'd1);
        wait_evts(1);
        ok = 1'b1;
        for (int i = 0; i < 8; i++) if (mem[32 + i] !== (32'hA500_0010 + 32'(i))) ok = 1'b0;
        chk("R4 dir0 destination data", {31'd0, ok}, 32'd1);
        chk("R5 dir0 handshake count", 32'(acc_n - a0), 32'd16);
        chk("R6 event id ch0", {24'd0, evt_log[0]}, 32'd8);
        rreg(0, 6, v);
        chk("R6 start cleared ch0", v, 32'd0);
        @(negedge clk);
        chk("R6 single-cycle event", {31'd0, evt_valid}, 32'd0);

        // R4 dir 1: external -> system, words 48..55 -> 0..7
        setup(2, 32'hC0, 32'h00, 32'h20, 1'b1);
        wreg(2, 6, 32'd1);
        wait_evts(2);
        ok = 1'b1;
        for (int i = 0; i < 8; i++) if (mem[i] !== (32'hA500_0030 + 32'(i))) ok = 1'b0;
        chk("R4 dir1 destination data", {31'd0, ok}, 32'd1);
        chk("R6 event id ch2", {24'd0, evt_log[1]}, 32'd10);

        // R5: zero length completes with no memory access
        a0 = acc_n;
        setup(3, 32'h80, 32'h40, 32'h0, 1'b0);
        wreg(3, 6, 32'd1);
        wait_evts(3);
        chk("R5 zero length no access", 32'(acc_n - a0), 32'd0);
        chk("R6 event id ch3", {24'd0, evt_log[2]}, 32'd11);

        // R5: bits above 28 ignored for the count (0xE0000020 -> 8 words)
        a0 = acc_n;
        setup(3, 32'h100, 32'h40, 32'hE000_0020, 1'b0);
        rreg(3, 2, v);
        chk("R2 length high-bit mask", v, 32'h8000_0020);
        wreg(3, 6, 32'd1);
        wait_evts(4);
        chk("R5 29-bit length word count", 32'(acc_n - a0), 32'd16);

        // R7/R8: three pending channels under a long copy on ch0
        for (int i = 0; i < 64; i++) snap[i] = mem[i];
        evt_n = 0;
        setup(0, 32'h80, 32'h00, 32'h40, 1'b0);
        setup(1, 32'hC0, 32'h40, 32'h20, 1'b0);
        setup(3, 32'h00, 32'h00, 32'h00, 1'b0);
        wreg(0, 6, 32'd1);
        wreg(3, 6, 32'd1);
        wreg(1, 6, 32'd1);
        rreg(0, 6, v);
        chk("R8 start reads 1 while busy", v, 32'd1);
        wreg(0, 0, 32'h100);
        rreg(0, 0, v);
        chk("R8 busy ext write ignored", v, 32'h80);
        wreg(0, 2, 32'h20);
        rreg(0, 2, v);
        chk("R8 busy length write ignored", v, 32'h40);
        wait_evts(3);
        chk("R7 first event ch0", {24'd0, evt_log[0]}, 32'd8);
        chk("R7 second event ch1", {24'd0, evt_log[1]}, 32'd9);
        chk("R7 third event ch3", {24'd0, evt_log[2]}, 32'd11);
        ok = 1'b1;
        for (int i = 0; i < 16; i++) if (mem[32 + i] !== snap[i]) ok = 1'b0;
        chk("R8 ch0 used original destination", {31'd0, ok}, 32'd1);
        ok = 1'b1;
        for (int i = 0; i < 8; i++) if (mem[48 + i] !== snap[16 + i]) ok = 1'b0;
        chk("R4 ch1 destination data", {31'd0, ok}, 32'd1);
        chk("R9 no request left open", {31'd0, mem_req}, 32'd0);

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule